// File: doc/BRIEF.md
# Serial Counter-Block Incrementer

This block advances the 128-bit counter block used by a block cipher in counter mode. It adds one to the counter with a single 16-bit incrementer rather than a full-width adder. The incrementer steps across eight 16-bit slices, one slice per clock, starting at the least significant slice and passing the carry upward. The cipher uses the counter value only in its first round, so the increment runs while the remaining rounds execute and does not slow the block rate.

A start strobe loads the current counter value, which the surrounding logic drives once that value has been consumed. The block then writes back one slice per cycle. It flags each written slice with a one-hot write enable so that a slice-organised register file can follow it. A done pulse marks the final write. With the default early-exit setting, the walk ends at the first slice that produces no carry. An all-ones counter wraps to zero after eight writes and raises no error.

Top module: `ctr_serial_inc`

## Requirements
- R1: While rst_ni is low, iv_o reads zero, slice_we_o reads zero and done_o is low.
- R2: A start_i sampled high while the block is idle loads iv_i into the counter, and iv_o shows it after that edge. No write enable or done pulse occurs in the cycle after the load.
- R3: On each clock edge after the load, the block adds the carry to exactly one slice. Slice k covers iv_o[16k+15:16k]. Slices are visited in rising order from k=0, and slice_we_o carries one-hot bit k in the cycle that slice k was written.
- R4: A slice holding 16'hFFFF becomes 16'h0000 and passes a carry of one to the next higher slice, which is written on the following cycle.
- R5: With early exit enabled (the default), the walk stops at the first slice whose increment produces no carry. done_o is a one-cycle pulse that coincides with that slice's write enable, and iv_o then equals the loaded value plus one, with iv_o[127] as the most significant bit. If the k lowest slices are all ones, done_o rises k+1 cycles after the load edge.
- R6: An all-ones counter wraps to zero. All eight slices are written and done_o pulses on the eighth cycle, with no error indication.
- R7: A start_i pulse that arrives while a walk is in progress is ignored. The walk continues, and the result is the increment of the originally loaded value.
- R8: After done_o, iv_o holds its value and slice_we_o stays zero until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load iv_i and begin an increment (ignored while busy) |
| iv_i | input | 128 | Counter value to increment |
| iv_o | output | 128 | Working and updated counter value |
| slice_we_o | output | 8 | One-hot marker of the slice written in the last cycle |
| done_o | output | 1 | One-cycle pulse on the final slice write |

## Verification
The assertions assume that start_i is a clean synchronous level sampled at rising edges, and that iv_i is stable whenever start_i is high while idle. They make no assumption about start_i while a walk is running, since such pulses must be ignored. The stimulus changes start_i and iv_i only at falling clock edges, and it holds start_i high for a single cycle per request. It also deliberately raises start_i with a different iv_i partway through some walks. Random counter values are biased so that 0 to 8 of their low slices are all ones, which covers every walk length and the full wrap.

// File: rtl/ctr_inc_pkg.sv
package ctr_inc_pkg;
  localparam int unsigned DEF_CTR_W   = 128;
  localparam int unsigned DEF_SLICE_W = 16;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_st_e;
endpackage

// File: rtl/ctr_slice_adder.sv
module ctr_slice_adder #(
  parameter int unsigned SW = 16
) (
  input  logic [SW-1:0] a_i,
  input  logic          cin_i,
  output logic [SW-1:0] sum_o,
  output logic          cout_o
);
  assign {cout_o, sum_o} = {1'b0, a_i} + {{SW{1'b0}}, cin_i};
endmodule

// File: rtl/ctr_walk_ctrl.sv
module ctr_walk_ctrl
  import ctr_inc_pkg::*;
#(
  parameter int unsigned N          = 8,
  parameter bit          EARLY_EXIT = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 cout_i,
  output logic                 load_o,
  output logic                 step_o,
  output logic [$clog2(N)-1:0] idx_o,
  output logic                 cin_o,
  output logic [N-1:0]         we_o,
  output logic                 done_o
);
  localparam int unsigned IDX_W = $clog2(N);

  walk_st_e          st_q;
  logic [IDX_W-1:0]  idx_q;
  logic              cin_q;
  logic [N-1:0]      we_q;
  logic              done_q;
  logic              last, finish;

  assign last   = (idx_q == IDX_W'(N - 1));
  assign finish = last || (EARLY_EXIT && !cout_i);
  assign load_o = (st_q == ST_IDLE) && start_i;
  assign step_o = (st_q == ST_WALK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      cin_q  <= 1'b0;
      we_q   <= '0;
      done_q <= 1'b0;
    end else begin
      we_q   <= '0;
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_WALK;
          idx_q <= '0;
          cin_q <= 1'b1;
        end
        ST_WALK: begin
          we_q  <= {{(N-1){1'b0}}, 1'b1} << idx_q;
          cin_q <= cout_i;
          if (finish) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign cin_o  = cin_q;
  assign we_o   = we_q;
  assign done_o = done_q;
endmodule

// File: rtl/ctr_serial_inc.sv
module ctr_serial_inc
  import ctr_inc_pkg::*;
#(
  parameter int unsigned CTR_W      = DEF_CTR_W,
  parameter int unsigned SLICE_W    = DEF_SLICE_W,
  parameter bit          EARLY_EXIT = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [CTR_W-1:0]           iv_i,
  output logic [CTR_W-1:0]           iv_o,
  output logic [CTR_W/SLICE_W-1:0]   slice_we_o,
  output logic                       done_o
);
  localparam int unsigned N     = CTR_W / SLICE_W;
  localparam int unsigned IDX_W = $clog2(N);

  logic [CTR_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]   idx;
  logic [SLICE_W-1:0] cur, sum;
  logic               cin, cout, load, step;

  ctr_walk_ctrl #(.N(N), .EARLY_EXIT(EARLY_EXIT)) i_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .cout_i (cout),
    .load_o (load),
    .step_o (step),
    .idx_o  (idx),
    .cin_o  (cin),
    .we_o   (slice_we_o),
    .done_o (done_o)
  );

  assign cur = cnt_q[idx*SLICE_W +: SLICE_W];

  ctr_slice_adder #(.SW(SLICE_W)) i_add (
    .a_i   (cur),
    .cin_i (cin),
    .sum_o (sum),
    .cout_o(cout)
  );

  for (genvar k = 0; k < N; k++) begin : g_slice
    always_comb begin
      if (load)
        cnt_d[k*SLICE_W +: SLICE_W] = iv_i[k*SLICE_W +: SLICE_W];
      else if (step && (idx == IDX_W'(k)))
        cnt_d[k*SLICE_W +: SLICE_W] = sum;
      else
        cnt_d[k*SLICE_W +: SLICE_W] = cnt_q[k*SLICE_W +: SLICE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign iv_o = cnt_q;
endmodule

// File: rtl/ctr_serial_inc_chk.sv
module ctr_serial_inc_chk #(
  parameter int unsigned N     = 8,
  parameter int unsigned CTR_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [N-1:0]     slice_we_o,
  input logic             done_o,
  input logic [CTR_W-1:0] iv_o,
  input logic             step_i
);
  // R3
  we_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slice_we_o));

  // R3
  step_writes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> ($countones(slice_we_o) == 1));

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> (slice_we_o == '0) && !done_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !start_i) |=> $stable(iv_o));

  // R5
  done_with_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (slice_we_o != '0));

  // R5
  done_ends_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !step_i);
endmodule

bind ctr_serial_inc ctr_serial_inc_chk #(.N(N), .CTR_W(CTR_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .slice_we_o(slice_we_o),
  .done_o    (done_o),
  .iv_o      (iv_o),
  .step_i    (step)
);

// File: tb/test_ctr_serial_inc.sv
`timescale 1ns/1ps
module test_ctr_serial_inc;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] iv_in = '0;
  logic [127:0] iv_out;
  logic [7:0]   we;
  logic         done;
  int           total = 0;
  int           bad = 0;
  int           cyc = 0;

  always #4 clk = ~clk;

  ctr_serial_inc i_ctr_serial_inc (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .iv_i      (iv_in),
    .iv_o      (iv_out),
    .slice_we_o(we),
    .done_o    (done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int walk_len(input logic [127:0] v);
    int k = 0;
    while (k < 8 && v[k*16 +: 16] == 16'hFFFF) k++;
    return (k == 8) ? 8 : k + 1;
  endfunction

  task automatic run_case(input logic [127:0] v, input bit inject);
    int len = walk_len(v);
    @(negedge clk); start = 1'b1; iv_in = v;
    @(negedge clk); start = 1'b0; iv_in = ~v;
    // R2: loaded, no write yet
    chk(iv_out == v, "R2 load", iv_out, v);
    chk(we == 8'h0 && !done, "R2 quiet", {119'b0, done, we}, 128'h0);
    for (int c = 1; c <= len; c++) begin
      start = inject && (c == 1);   // R7: strobe during walk
      @(negedge clk);
      start = 1'b0;
      // R3/R4: one-hot write in rising slice order
      chk(we == (8'h1 << (c - 1)), "R3 slice order", {120'b0, we}, {120'b0, 8'h1 << (c - 1)});
      chk(done == (c == len), "R5 done timing", {127'b0, done}, {127'b0, c == len});
    end
    if (len == 8 && v == '1)
      chk(iv_out == '0, "R6 wrap", iv_out, 128'h0);
    else if (inject)
      chk(iv_out == v + 128'd1, "R7 ignored start", iv_out, v + 128'd1);
    else
      chk(iv_out == v + 128'd1, "R5 result", iv_out, v + 128'd1);
    @(negedge clk);
    @(negedge clk);
    chk(iv_out == v + 128'd1 && we == 8'h0 && !done, "R8 hold", iv_out, v + 128'd1);
  endtask

  initial begin
    logic [127:0] v;
    void'($urandom(32'h5A17));
    @(negedge clk);
    // R1
    chk(iv_out == '0 && we == 8'h0 && !done, "R1 reset", iv_out, 128'h0);
    @(negedge clk);
    rst_n = 1'b1;
    run_case(128'h0, 1'b0);
    run_case(128'h0000_0000_0000_0000_0000_0000_0000_FFFF, 1'b0);   // R4
    run_case(128'h1234_0000_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b1);   // R4 R7
    run_case({16'h7FFF, {112{1'b1}}}, 1'b0);
    run_case('1, 1'b0);                                              // R6
    run_case('1, 1'b1);                                              // R6 R7
    for (int n = 0; n < 40; n++) begin
      int t = $urandom % 9;
      v = {$urandom, $urandom, $urandom, $urandom};
      for (int s = 0; s < t; s++) v[s*16 +: 16] = 16'hFFFF;
      run_case(v, (n % 3) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule